// File: doc/BRIEF.md
# Speculative Result Window with Tag Allocation

This block is the in-order window of an out-of-order core that renames registers. Each instruction entering dispatch claims one slot in a circular window. The slot records the architectural destination register, and its index is handed back as the instruction's tag. Functional units later return results by tag, and those results stay speculative inside the window. The oldest slot drains to the architectural register bank once it holds a result, so the register bank only ever sees state in program order.

Two source-lookup ports serve dispatch when it reads operands. For a register number, a port reports whether any live slot will write that register. When several live slots write it, the port reports the youngest of them. If that slot already holds its result, or the result arrives on the write port in the same cycle, the port also returns the value and flags it ready. Otherwise it returns only the tag, and the caller waits for that tag.

A mispredicted branch is repaired by a flush naming the branch's tag. Every slot allocated after the branch is discarded at once, and allocation resumes right after the branch slot.

Top module: `spec_result_window`

## Requirements
- R1: After reset the window is empty: `disp_ready` is 1, `disp_tag` is 0, `cm_valid` is 0 and every lookup port reports no hit.
- R2: A dispatch is accepted in a cycle where `disp_valid` and `disp_ready` are both 1. The tag it receives is the value on `disp_tag` in that cycle. Tags are handed out consecutively modulo the depth (default 8 slots, 3-bit tags), starting from 0.
- R3: With all slots live, `disp_ready` is 0 and a `disp_valid` pulse allocates nothing. After one retirement, `disp_ready` returns to 1.
- R4: A lookup of a register that no live slot writes reports `src_hit`=0.
- R5: When several live slots write the looked-up register, the lookup returns the tag of the most recently allocated one (`src_hit`=1). While that slot has no result, `src_rdy` is 0.
- R6: Once the youngest writer holds a result, the lookup returns `src_rdy`=1 and that result on `src_val`.
- R7: If the result for the youngest writer's tag is presented on the write port in the same cycle as the lookup, the lookup returns `src_rdy`=1 with the incoming data in that cycle.
- R8: A result write to a slot that already holds a result is ignored, and the first value is kept.
- R9: `cm_valid` is 1 only when the oldest slot holds a result. Slots retire one per cycle and strictly in allocation order, even when results arrive out of order.
- R10: While `cm_valid` is 1 and `cm_ready` is 0, `cm_valid`, `cm_reg` and `cm_data` hold steady. A retirement happens only in a cycle with both set.
- R11: `flush_valid` with `flush_tag` naming a live slot discards every slot allocated after it. The next tag handed out is `flush_tag`+1. No dispatch is accepted in the flush cycle (`disp_ready` is 0).
- R12: Lookups see only slots allocated in earlier cycles. A register dispatched in the same cycle as its lookup is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Window can take a dispatch this cycle |
| disp_dst | input | REG_W | Destination register of the dispatching instruction |
| disp_tag | output | TAG_W | Tag given to an accepted dispatch |
| src_reg | input | NSRC*REG_W | Register number per lookup port (port p at bits p*REG_W) |
| src_hit | output | NSRC | A live slot writes this register |
| src_tag | output | NSRC*TAG_W | Tag of the youngest such slot |
| src_rdy | output | NSRC | Value is available on src_val |
| src_val | output | NSRC*DATA_W | Result of the youngest writer |
| wb_valid | input | 1 | Result write strobe (always accepted) |
| wb_tag | input | TAG_W | Slot the result belongs to |
| wb_data | input | DATA_W | Result value |
| cm_valid | output | 1 | Oldest slot is ready to retire |
| cm_ready | input | 1 | Register bank accepts the retirement |
| cm_reg | output | REG_W | Register written by the retiring slot |
| cm_data | output | DATA_W | Value written by the retiring slot |
| flush_valid | input | 1 | Mispredict repair request |
| flush_tag | input | TAG_W | Tag of the mispredicted branch |

## Verification
The dispatch tag, the lookup results and the commit outputs all follow from the current slot state without a register in between. The bench therefore samples them 1 ns after driving, within the same cycle, and expects the effect of a dispatch, write, retirement or flush one rising edge later, at the next falling-edge sample. Same-cycle effects are the bypass of a write into a lookup (R7) and the refusal of dispatch while a flush is applied (R11). They are checked in the cycle of the stimulus itself. Every other stimulus is applied at a falling edge, and its effect is checked after the following rising edge.

// File: rtl/srw_pkg.sv
`timescale 1ns/1ps
package srw_pkg;
  localparam int DEF_DEPTH  = 8;
  localparam int DEF_REG_W  = 5;
  localparam int DEF_DATA_W = 32;
  localparam int DEF_NSRC   = 2;

  // occupancy update selected from {push, pop}
  typedef enum logic [1:0] {
    OCC_HOLD = 2'b00,
    OCC_POP  = 2'b01,
    OCC_PUSH = 2'b10,
    OCC_BOTH = 2'b11
  } occ_op_e;
endpackage

// File: rtl/srw_ring_ptrs.sv
`timescale 1ns/1ps
module srw_ring_ptrs
  import srw_pkg::*;
#(
  parameter int DEPTH = DEF_DEPTH,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = TAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [TAG_W-1:0] flush_tag,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic [DEPTH-1:0] live
);
  // DEPTH is a power of two so that tag arithmetic wraps naturally
  logic [TAG_W-1:0] head_n, tail_n;
  logic [CNT_W-1:0] count_n;
  logic [TAG_W-1:0] flush_age;
  occ_op_e          op;

  assign full      = (count == CNT_W'(DEPTH));
  assign flush_age = flush_tag - head;
  assign op        = occ_op_e'({push, pop});

  for (genvar i = 0; i < DEPTH; i++) begin : g_live
    logic [TAG_W-1:0] age;
    assign age     = TAG_W'(i) - head;
    assign live[i] = ({1'b0, age} < count);
  end

  always_comb begin
    head_n  = pop ? head + TAG_W'(1) : head;
    tail_n  = tail;
    count_n = count;
    if (flush) begin
      tail_n  = flush_tag + TAG_W'(1);
      count_n = {1'b0, flush_age} + CNT_W'(1) - CNT_W'(pop);
    end else begin
      case (op)
        OCC_PUSH: begin tail_n = tail + TAG_W'(1); count_n = count + CNT_W'(1); end
        OCC_POP:  count_n = count - CNT_W'(1);
        OCC_BOTH: tail_n = tail + TAG_W'(1);
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= head_n;
      tail  <= tail_n;
      count <= count_n;
    end
  end

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/srw_slot_store.sv
`timescale 1ns/1ps
module srw_slot_store
  import srw_pkg::*;
#(
  parameter int DEPTH  = DEF_DEPTH,
  parameter int REG_W  = DEF_REG_W,
  parameter int DATA_W = DEF_DATA_W,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc,
  input  logic [TAG_W-1:0]             alloc_tag,
  input  logic [REG_W-1:0]             alloc_dst,
  input  logic                         wb_valid,
  input  logic [TAG_W-1:0]             wb_tag,
  input  logic [DATA_W-1:0]            wb_data,
  input  logic [DEPTH-1:0]             live,
  output logic [DEPTH-1:0][REG_W-1:0]  dst_q,
  output logic [DEPTH-1:0]             done_q,
  output logic [DEPTH-1:0][DATA_W-1:0] data_q
);
  logic wb_take;
  assign wb_take = wb_valid && live[wb_tag] && !done_q[wb_tag];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic sel_alloc, sel_wb;
    assign sel_alloc = alloc && (alloc_tag == TAG_W'(i));
    assign sel_wb    = wb_take && (wb_tag == TAG_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        done_q[i] <= 1'b0;
      end else if (sel_alloc) begin
        done_q[i] <= 1'b0;
      end else if (sel_wb) begin
        done_q[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_alloc) dst_q[i] <= alloc_dst;
      if (sel_wb)    data_q[i] <= wb_data;
    end
  end

  // R8
  done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && done_q[wb_tag] && !(alloc && alloc_tag == wb_tag))
      |=> $stable(data_q[$past(wb_tag)]));
endmodule

// File: rtl/srw_src_lookup.sv
`timescale 1ns/1ps
module srw_src_lookup
  import srw_pkg::*;
#(
  parameter int DEPTH  = DEF_DEPTH,
  parameter int REG_W  = DEF_REG_W,
  parameter int DATA_W = DEF_DATA_W,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [REG_W-1:0]             src,
  input  logic [TAG_W-1:0]             head,
  input  logic [DEPTH-1:0]             live,
  input  logic [DEPTH-1:0][REG_W-1:0]  dst_q,
  input  logic [DEPTH-1:0]             done_q,
  input  logic [DEPTH-1:0][DATA_W-1:0] data_q,
  input  logic                         wb_valid,
  input  logic [TAG_W-1:0]             wb_tag,
  input  logic [DATA_W-1:0]            wb_data,
  output logic                         hit,
  output logic [TAG_W-1:0]             tag,
  output logic                         rdy,
  output logic [DATA_W-1:0]            val
);
  // walk from oldest to youngest; the last match is the youngest writer
  always_comb begin
    hit = 1'b0;
    tag = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [TAG_W-1:0] idx;
      idx = head + TAG_W'(k);
      if (live[idx] && dst_q[idx] == src) begin
        hit = 1'b1;
        tag = idx;
      end
    end
  end

  always_comb begin
    rdy = 1'b0;
    val = data_q[tag];
    if (hit) begin
      if (done_q[tag]) begin
        rdy = 1'b1;
      end else if (wb_valid && wb_tag == tag) begin
        rdy = 1'b1;
        val = wb_data;
      end
    end
  end

  // R5
  youngest_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (live[tag] && dst_q[tag] == src));
  // R7
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wb_valid && wb_tag == tag && !done_q[tag]) |-> (rdy && val == wb_data));
endmodule

// File: rtl/spec_result_window.sv
`timescale 1ns/1ps
module spec_result_window
  import srw_pkg::*;
#(
  parameter int DEPTH  = DEF_DEPTH,
  parameter int REG_W  = DEF_REG_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int NSRC   = DEF_NSRC,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = TAG_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  output logic                     disp_ready,
  input  logic [REG_W-1:0]         disp_dst,
  output logic [TAG_W-1:0]         disp_tag,
  input  logic [NSRC*REG_W-1:0]    src_reg,
  output logic [NSRC-1:0]          src_hit,
  output logic [NSRC*TAG_W-1:0]    src_tag,
  output logic [NSRC-1:0]          src_rdy,
  output logic [NSRC*DATA_W-1:0]   src_val,
  input  logic                     wb_valid,
  input  logic [TAG_W-1:0]         wb_tag,
  input  logic [DATA_W-1:0]        wb_data,
  output logic                     cm_valid,
  input  logic                     cm_ready,
  output logic [REG_W-1:0]         cm_reg,
  output logic [DATA_W-1:0]        cm_data,
  input  logic                     flush_valid,
  input  logic [TAG_W-1:0]         flush_tag
);
  logic [TAG_W-1:0]             head, tail;
  logic [CNT_W-1:0]             count;
  logic                         full;
  logic [DEPTH-1:0]             live;
  logic [DEPTH-1:0][REG_W-1:0]  dst_q;
  logic [DEPTH-1:0]             done_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;
  logic                         disp_fire, cm_fire;

  assign disp_ready = !full && !flush_valid;
  assign disp_fire  = disp_valid && disp_ready;
  assign disp_tag   = tail;

  assign cm_valid = live[head] && done_q[head];
  assign cm_fire  = cm_valid && cm_ready;
  assign cm_reg   = dst_q[head];
  assign cm_data  = data_q[head];

  srw_ring_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (disp_fire),
    .pop       (cm_fire),
    .flush     (flush_valid),
    .flush_tag (flush_tag),
    .head      (head),
    .tail      (tail),
    .count     (count),
    .full      (full),
    .live      (live)
  );

  srw_slot_store #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc     (disp_fire),
    .alloc_tag (tail),
    .alloc_dst (disp_dst),
    .wb_valid  (wb_valid),
    .wb_tag    (wb_tag),
    .wb_data   (wb_data),
    .live      (live),
    .dst_q     (dst_q),
    .done_q    (done_q),
    .data_q    (data_q)
  );

  for (genvar p = 0; p < NSRC; p++) begin : g_src
    srw_src_lookup #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_lookup (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src_reg[p*REG_W +: REG_W]),
      .head     (head),
      .live     (live),
      .dst_q    (dst_q),
      .done_q   (done_q),
      .data_q   (data_q),
      .wb_valid (wb_valid),
      .wb_tag   (wb_tag),
      .wb_data  (wb_data),
      .hit      (src_hit[p]),
      .tag      (src_tag[p*TAG_W +: TAG_W]),
      .rdy      (src_rdy[p]),
      .val      (src_val[p*DATA_W +: DATA_W])
    );
  end

  // R2
  tag_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> disp_tag == TAG_W'($past(disp_tag) + 1'b1));
  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_ready && !flush_valid && !(cm_valid && cm_ready)) |=> !disp_ready);
  // R9
  empty_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !cm_valid);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_ready) |=> (cm_valid && $stable(cm_reg) && $stable(cm_data)));
  // R11
  flush_tag_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> live[flush_tag]);
endmodule

// File: tb/spec_result_window_test.sv
`timescale 1ns/1ps
module spec_result_window_test;
  localparam int REG_W = 5, DATA_W = 32, TAG_W = 3, NSRC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0, disp_ready;
  logic [REG_W-1:0] disp_dst = '0;
  logic [TAG_W-1:0] disp_tag;
  logic [NSRC*REG_W-1:0] src_reg = '0;
  logic [NSRC-1:0] src_hit, src_rdy;
  logic [NSRC*TAG_W-1:0] src_tag;
  logic [NSRC*DATA_W-1:0] src_val;
  logic wb_valid = 1'b0;
  logic [TAG_W-1:0] wb_tag = '0;
  logic [DATA_W-1:0] wb_data = '0;
  logic cm_valid, cm_ready = 1'b0;
  logic [REG_W-1:0] cm_reg;
  logic [DATA_W-1:0] cm_data;
  logic flush_valid = 1'b0;
  logic [TAG_W-1:0] flush_tag = '0;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spec_result_window uut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_dst(disp_dst), .disp_tag(disp_tag),
    .src_reg(src_reg), .src_hit(src_hit), .src_tag(src_tag), .src_rdy(src_rdy), .src_val(src_val),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_reg(cm_reg), .cm_data(cm_data),
    .flush_valid(flush_valid), .flush_tag(flush_tag)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_src(input int p, input string req, input logic hit, input logic [TAG_W-1:0] tag,
                         input logic rdy, input logic [DATA_W-1:0] val);
    chk(req, $sformatf("hit[%0d]", p), src_hit[p], hit);
    if (hit) begin
      chk(req, $sformatf("tag[%0d]", p), src_tag[p*TAG_W +: TAG_W], tag);
      chk(req, $sformatf("rdy[%0d]", p), src_rdy[p], rdy);
      if (rdy) chk(req, $sformatf("val[%0d]", p), src_val[p*DATA_W +: DATA_W], val);
    end
  endtask

  task automatic set_src(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b);
    src_reg = {b, a};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; disp_valid = 1'b0; wb_valid = 1'b0; cm_ready = 1'b0; flush_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic disp(input logic [REG_W-1:0] dst, input logic [TAG_W-1:0] exp_tag, input string req);
    @(negedge clk);
    disp_valid = 1'b1; disp_dst = dst;
    #1;
    chk(req, "disp_ready", disp_ready, 1'b1);
    chk(req, "disp_tag", disp_tag, exp_tag);
    @(posedge clk);
    #1 disp_valid = 1'b0;
  endtask

  task automatic wb(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wb_valid = 1'b1; wb_tag = t; wb_data = d;
    @(posedge clk);
    #1 wb_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    set_src(5'd1, 5'd0);
    @(negedge clk); #1;
    chk("R1", "disp_ready", disp_ready, 1'b1);
    chk("R1", "disp_tag", disp_tag, 3'd0);
    chk("R1", "cm_valid", cm_valid, 1'b0);
    chk("R1", "src_hit", src_hit, 2'b00);
  endtask

  task automatic t_sequence();
    do_reset();
    disp(5'd1, 3'd0, "R2");
    disp(5'd2, 3'd1, "R2");
    disp(5'd3, 3'd2, "R2");
    @(negedge clk); #1;
    chk("R2", "next tag", disp_tag, 3'd3);
  endtask

  task automatic t_lookup();
    do_reset();
    disp(5'd5, 3'd0, "R2");
    disp(5'd6, 3'd1, "R2");
    // R12: lookup in the dispatch cycle does not see the new slot
    @(negedge clk);
    disp_valid = 1'b1; disp_dst = 5'd5; set_src(5'd5, 5'd12);
    #1;
    chk_src(0, "R12", 1'b1, 3'd0, 1'b0, '0);
    disp_dst = 5'd12;
    #0.1;
    chk_src(1, "R12", 1'b0, '0, 1'b0, '0);
    @(posedge clk);
    #1 disp_valid = 1'b0;
    @(negedge clk); #1;
    chk_src(1, "R12", 1'b1, 3'd2, 1'b0, '0);
    disp(5'd5, 3'd3, "R2");
    set_src(5'd5, 5'd7);
    @(negedge clk); #1;
    chk_src(0, "R5", 1'b1, 3'd3, 1'b0, '0);
    chk_src(1, "R4", 1'b0, '0, 1'b0, '0);
    wb(3'd0, 32'hAAAA_0000);
    @(negedge clk); #1;
    chk_src(0, "R5", 1'b1, 3'd3, 1'b0, '0);
    wb(3'd3, 32'hBBBB_0003);
    set_src(5'd5, 5'd6);
    @(negedge clk); #1;
    chk_src(0, "R6", 1'b1, 3'd3, 1'b1, 32'hBBBB_0003);
    chk_src(1, "R5", 1'b1, 3'd1, 1'b0, '0);
  endtask

  task automatic t_bypass();
    do_reset();
    disp(5'd9, 3'd0, "R2");
    @(negedge clk);
    set_src(5'd9, 5'd9);
    wb_valid = 1'b1; wb_tag = 3'd0; wb_data = 32'h0000_0077;
    #1;
    chk_src(0, "R7", 1'b1, 3'd0, 1'b1, 32'h77);
    chk_src(1, "R7", 1'b1, 3'd0, 1'b1, 32'h77);
    @(posedge clk);
    #1 wb_valid = 1'b0;
    wb(3'd0, 32'h0000_0022);
    @(negedge clk); #1;
    chk_src(0, "R8", 1'b1, 3'd0, 1'b1, 32'h77);
  endtask

  task automatic t_commit_order();
    do_reset();
    cm_ready = 1'b1;
    disp(5'd1, 3'd0, "R2");
    disp(5'd2, 3'd1, "R2");
    disp(5'd3, 3'd2, "R2");
    wb(3'd2, 32'hC2);
    @(negedge clk); #1;
    chk("R9", "cm_valid head pending", cm_valid, 1'b0);
    wb(3'd1, 32'hC1);
    @(negedge clk); #1;
    chk("R9", "cm_valid head pending", cm_valid, 1'b0);
    wb(3'd0, 32'hC0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R9", "cm_valid", cm_valid, 1'b1);
      chk("R9", "cm_reg", cm_reg, 5'(i + 1));
      chk("R9", "cm_data", cm_data, 32'hC0 + i);
    end
    @(negedge clk); #1;
    chk("R9", "cm_valid drained", cm_valid, 1'b0);
    cm_ready = 1'b0;
  endtask

  task automatic t_backpressure();
    do_reset();
    disp(5'd7, 3'd0, "R2");
    wb(3'd0, 32'h5A);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R10", "cm_valid held", cm_valid, 1'b1);
      chk("R10", "cm_reg held", cm_reg, 5'd7);
      chk("R10", "cm_data held", cm_data, 32'h5A);
    end
    @(negedge clk);
    cm_ready = 1'b1;
    @(posedge clk);
    #1 cm_ready = 1'b0;
    set_src(5'd7, 5'd0);
    @(negedge clk); #1;
    chk("R10", "cm_valid after retire", cm_valid, 1'b0);
    chk_src(0, "R4", 1'b0, '0, 1'b0, '0);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < 8; i++) disp(5'(i + 1), 3'(i), "R2");
    @(negedge clk);
    disp_valid = 1'b1; disp_dst = 5'd20;
    #1;
    chk("R3", "disp_ready when full", disp_ready, 1'b0);
    @(posedge clk);
    #1 disp_valid = 1'b0;
    set_src(5'd20, 5'd8);
    @(negedge clk); #1;
    chk_src(0, "R3", 1'b0, '0, 1'b0, '0);
    chk_src(1, "R3", 1'b1, 3'd7, 1'b0, '0);
    wb(3'd0, 32'h11);
    @(negedge clk);
    cm_ready = 1'b1;
    @(posedge clk);
    #1 cm_ready = 1'b0;
    @(negedge clk); #1;
    chk("R3", "disp_ready after retire", disp_ready, 1'b1);
    chk("R3", "disp_tag wraps", disp_tag, 3'd0);
  endtask

  task automatic t_flush();
    do_reset();
    for (int i = 0; i < 4; i++) disp(5'(i + 1), 3'(i), "R2");
    @(negedge clk);
    flush_valid = 1'b1; flush_tag = 3'd1;
    disp_valid = 1'b1; disp_dst = 5'd9;
    #1;
    chk("R11", "disp_ready during flush", disp_ready, 1'b0);
    @(posedge clk);
    #1 begin flush_valid = 1'b0; disp_valid = 1'b0; end
    set_src(5'd3, 5'd4);
    @(negedge clk); #1;
    chk_src(0, "R11", 1'b0, '0, 1'b0, '0);
    chk_src(1, "R11", 1'b0, '0, 1'b0, '0);
    chk("R11", "disp_tag after flush", disp_tag, 3'd2);
    set_src(5'd2, 5'd9);
    #0.1;
    chk_src(0, "R11", 1'b1, 3'd1, 1'b0, '0);
    chk_src(1, "R11", 1'b0, '0, 1'b0, '0);
    disp(5'd9, 3'd2, "R11");
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_lookup();
    t_bypass();
    t_commit_order();
    t_backpressure();
    t_full();
    t_flush();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule